// File: doc/BRIEF.md
# Quad-Word Serial Link Transmitter

This block sends 128-bit quad-words to a peer over a narrow point-to-point link. The host pushes a quad-word, with a flag marking the end of a block, into a two-slot transmit buffer. A 128-bit shift register that the host cannot see takes the oldest word from the buffer and serializes it MSB first. The data bus is four lanes wide in throughput mode and one lane wide in minimum-wiring mode. The block forwards the link clock with the data, and the data changes on both edges of that clock.

The core clock runs at twice the link rate. The forwarded clock toggles once per core cycle while a word is in flight, and each toggle carries one beat. The receiver's acknowledge line is sampled only between quad-words, so a word that has started is always sent to the end. A block-completion output goes high for every beat of the final word of a block. Optional timeout logic discards a word that the receiver has refused for too long.

Top module: `qlink_tx`

## Requirements
- R1: A host write (`wr_en` high for one cycle) is stored in the buffer when fewer than two words are held. `st_full` is high exactly when two words are held, and it drops in the cycle after the shifter takes a word from a full buffer.
- R2: With `cfg_one_bit` = 0, each quad-word is sent as 32 beats on `lnk_dat[3:0]`, starting with bits 127:124. `lnk_clk` changes level on every core cycle of a word and is low again after the last beat.
- R3: With `cfg_one_bit` = 1, each quad-word is sent as 128 beats on `lnk_dat[0]`, bit 127 first, and `lnk_dat[3:1]` stays 0. The width is taken at the start of each word.
- R4: While transmission is enabled, `lnk_dat` changes only in a cycle in which `lnk_clk` also changes, so each clock edge, rising or falling, carries exactly one beat.
- R5: While `cfg_tx_en` is 0, `lnk_clk`, `lnk_dat` and `lnk_blk` are held at 0, no word is started, and buffered words are kept until transmission is enabled.
- R6: A word starts only when `lnk_ack` is 1 while the shifter is idle. While `lnk_ack` is 0 between words, `lnk_clk` stays low and `lnk_dat` keeps its value.
- R7: When `cfg_blk_en` is 1, `lnk_blk` is high for every beat of a word that was written with `wr_last` = 1. Otherwise `lnk_blk` is 0.
- R8: A write while `st_full` is high is discarded, and it sets `st_ovf`, which stays set until reset.
- R9: When `cfg_tmo_en` is 1 and a waiting word has been refused by a low `lnk_ack` for 1024 consecutive cycles, `st_tmo` is set and stays set until reset, and that word is discarded without being sent.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the link rate |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 128 | Quad-word to send |
| wr_last | input | 1 | Written word ends a block |
| cfg_tx_en | input | 1 | Transmission enable |
| cfg_one_bit | input | 1 | 1 selects one lane, 0 selects four lanes |
| cfg_tmo_en | input | 1 | Acknowledge timeout enable |
| cfg_blk_en | input | 1 | Block-completion signalling enable |
| lnk_ack | input | 1 | Receiver ready for the next quad-word |
| lnk_clk | output | 1 | Forwarded link clock |
| lnk_dat | output | 4 | Link data lanes |
| lnk_blk | output | 1 | Block-completion flag |
| st_full | output | 1 | Both buffer slots occupied |
| st_ovf | output | 1 | Sticky write-overflow status |
| st_tmo | output | 1 | Sticky acknowledge-timeout status |

## Verification
The assertions assume that reset is applied at the start and that configuration is held steady while a word is in flight, apart from `cfg_tx_en` itself. The data-stability property also assumes that transmission was enabled in the previous cycle. The stimulus changes lane width and block signalling only after the expected-word queue has drained and no beat is outstanding. It clears `cfg_tx_en` only while the shifter is idle. The acknowledge line is randomized freely, because the design samples it only at word boundaries.

// File: rtl/qlink_pkg.sv
// Shared definitions for the quad-word link transmitter.
// Assumes the transfer unit is fixed at 128 bits.
package qlink_pkg;
    localparam int QW_BITS = 128;

    // Number of beats in one quad-word for a given lane count.
    function automatic int beats_for(input int qw, input int lanes);
        return qw / lanes;
    endfunction
endpackage

// File: rtl/qlink_txbuf.sv
// Small FIFO that holds host-written words (data plus block-end flag).
// Assumes DEPTH is a power of two; a push while full is dropped here,
// and the caller is responsible for flagging it.
module qlink_txbuf #(
    parameter int W     = 129,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/qlink_stall.sv
// Counts consecutive cycles in which a waiting word is refused and
// pulses expire on the LIMIT-th such cycle. Assumes arm is steady.
module qlink_stall #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    input  logic arm,
    output logic expire
);
    localparam int CW = $clog2(LIMIT) + 1;

    logic [CW-1:0] cnt;

    assign expire = stall && arm && (cnt == CW'(LIMIT - 1));

    // Consecutive-stall counter, cleared on any break or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (!stall || !arm)  cnt <= '0;
        else if (expire)          cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/qlink_ser.sv
// Serializer: loads a quad-word on start, then emits one beat and one
// forwarded-clock transition per cycle, MSB first. The lane width is
// latched at load. Clearing en abandons any word in progress.
module qlink_ser #(
    parameter int QW    = 128,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             narrow,
    input  logic             blk_en,
    input  logic             start,
    input  logic [QW-1:0]    word,
    input  logic             last,
    output logic             idle,
    output logic             lclk,
    output logic [LANES-1:0] ldat,
    output logic             lblk
);
    localparam int CW         = $clog2(QW);
    localparam int WIDE_BEATS = qlink_pkg::beats_for(QW, LANES);

    logic          run, narrow_q, last_q;
    logic [QW-1:0] shreg;
    logic [CW-1:0] cnt;
    logic [LANES-1:0] beat;

    assign idle = !run;
    assign beat = narrow_q ? {{(LANES-1){1'b0}}, shreg[QW-1]}
                           : shreg[QW-1 -: LANES];

    // Load, shift and drive the link outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            narrow_q <= 1'b0;
            last_q   <= 1'b0;
            shreg    <= '0;
            cnt      <= '0;
            lclk     <= 1'b0;
            ldat     <= '0;
            lblk     <= 1'b0;
        end else if (!en) begin
            run  <= 1'b0;
            lclk <= 1'b0;
            ldat <= '0;
            lblk <= 1'b0;
        end else if (run) begin
            ldat  <= beat;
            lclk  <= ~lclk;
            lblk  <= last_q && blk_en;
            shreg <= narrow_q ? (shreg << 1) : (shreg << LANES);
            cnt   <= cnt - 1'b1;
            if (cnt == '0) run <= 1'b0;
        end else begin
            lblk <= 1'b0;
            if (start) begin
                shreg    <= word;
                run      <= 1'b1;
                narrow_q <= narrow;
                last_q   <= last;
                cnt      <= narrow ? CW'(QW - 1) : CW'(WIDE_BEATS - 1);
            end
        end
    end
endmodule

// File: rtl/qlink_tx.sv
// Top level of the quad-word link transmitter: two-slot buffer,
// serializer and acknowledge-timeout counter, plus sticky status.
// Assumes clk runs at twice the forwarded link clock rate.
module qlink_tx #(
    parameter int QW        = qlink_pkg::QW_BITS,
    parameter int LANES     = 4,
    parameter int BUF_DEPTH = 2,
    parameter int TMO_LIMIT = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [QW-1:0]    wr_data,
    input  logic             wr_last,
    input  logic             cfg_tx_en,
    input  logic             cfg_one_bit,
    input  logic             cfg_tmo_en,
    input  logic             cfg_blk_en,
    input  logic             lnk_ack,
    output logic             lnk_clk,
    output logic [LANES-1:0] lnk_dat,
    output logic             lnk_blk,
    output logic             st_full,
    output logic             st_ovf,
    output logic             st_tmo
);
    localparam int EW = QW + 1;

    logic [EW-1:0] head;
    logic          empty, full, ser_idle, start, stall, expire;

    assign start   = ser_idle && cfg_tx_en && !empty && lnk_ack;
    assign stall   = ser_idle && cfg_tx_en && !empty && !lnk_ack;
    assign st_full = full;

    qlink_txbuf #(.W(EW), .DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .din   ({wr_last, wr_data}),
        .pop   (start || expire),
        .dout  (head),
        .empty (empty),
        .full  (full)
    );

    qlink_ser #(.QW(QW), .LANES(LANES)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_tx_en),
        .narrow (cfg_one_bit),
        .blk_en (cfg_blk_en),
        .start  (start),
        .word   (head[QW-1:0]),
        .last   (head[QW]),
        .idle   (ser_idle),
        .lclk   (lnk_clk),
        .ldat   (lnk_dat),
        .lblk   (lnk_blk)
    );

    qlink_stall #(.LIMIT(TMO_LIMIT)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (stall),
        .arm    (cfg_tmo_en),
        .expire (expire)
    );

    // Sticky overflow and timeout status, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_ovf <= 1'b0;
            st_tmo <= 1'b0;
        end else begin
            if (wr_en && full) st_ovf <= 1'b1;
            if (expire)        st_tmo <= 1'b1;
        end
    end
endmodule

// File: rtl/qlink_tx_chk.sv
// Port-level properties of the link transmitter, bound to every instance.
module qlink_tx_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             cfg_tx_en,
    input logic             cfg_blk_en,
    input logic             lnk_clk,
    input logic [LANES-1:0] lnk_dat,
    input logic             lnk_blk,
    input logic             st_full,
    input logic             st_ovf,
    input logic             st_tmo
);
    a_r5_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tx_en |=> (!lnk_clk && lnk_dat == '0 && !lnk_blk));

    a_r7_blk_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_blk_en |=> !lnk_blk);

    a_r8_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_full) |=> st_ovf);

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_ovf |=> st_ovf);

    a_r9_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_tmo |=> st_tmo);

    a_r4_data_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_tx_en) && $stable(lnk_clk)) |-> $stable(lnk_dat));
endmodule

bind qlink_tx qlink_tx_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .cfg_tx_en  (cfg_tx_en),
    .cfg_blk_en (cfg_blk_en),
    .lnk_clk    (lnk_clk),
    .lnk_dat    (lnk_dat),
    .lnk_blk    (lnk_blk),
    .st_full    (st_full),
    .st_ovf     (st_ovf),
    .st_tmo     (st_tmo)
);

// File: tb/tb_qlink_tx.sv
module tb_qlink_tx;
    localparam int QW    = 128;
    localparam int LANES = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [QW-1:0]    wr_data = '0;
    logic             wr_last = 1'b0;
    logic             cfg_tx_en = 1'b0, cfg_one_bit = 1'b0;
    logic             cfg_tmo_en = 1'b0, cfg_blk_en = 1'b0;
    logic             lnk_ack = 1'b0;
    logic             lnk_clk, lnk_blk, st_full, st_ovf, st_tmo;
    logic [LANES-1:0] lnk_dat;

    always #2 clk = ~clk;

    qlink_tx dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_last(wr_last), .cfg_tx_en(cfg_tx_en), .cfg_one_bit(cfg_one_bit),
        .cfg_tmo_en(cfg_tmo_en), .cfg_blk_en(cfg_blk_en), .lnk_ack(lnk_ack),
        .lnk_clk(lnk_clk), .lnk_dat(lnk_dat), .lnk_blk(lnk_blk),
        .st_full(st_full), .st_ovf(st_ovf), .st_tmo(st_tmo)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [QW-1:0] act,
                       input logic [QW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [QW-1:0] rnd_word();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic int beats_of(input bit narrow);
        return narrow ? QW : QW / LANES;
    endfunction

    // Reference queue of words expected on the link: {last, data}.
    logic [QW:0] expq[$];
    bit   mon_narrow = 0, mon_blk_en = 0;
    logic prev_clk = 0, prev_en = 0;
    logic [LANES-1:0] prev_dat = '0;
    logic [QW-1:0] acc = '0;
    int   beats = 0, toggles = 0, words_rx = 0, r4_viol = 0, r2_gap = 0;
    bit   blk_all = 1, blk_any = 0, lane_bad = 0;

    // Link monitor: one beat per observed clock transition.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_clk = 0; prev_dat = '0; beats = 0; acc = '0;
        end else begin
            if (lnk_clk === prev_clk) begin
                if (lnk_dat !== prev_dat && cfg_tx_en && prev_en) r4_viol++;
                if (beats != 0) r2_gap++;
            end else begin
                toggles++;
                if (mon_narrow) begin
                    acc = {acc[QW-2:0], lnk_dat[0]};
                    if (lnk_dat[LANES-1:1] != '0) lane_bad = 1;
                end else begin
                    acc = {acc[QW-LANES-1:0], lnk_dat};
                end
                blk_all &= lnk_blk;
                blk_any |= lnk_blk;
                beats++;
                if (beats == beats_of(mon_narrow)) begin
                    words_rx++;
                    if (expq.size() == 0) begin
                        chk(0, "R1 unexpected word", acc, '0);
                    end else begin
                        logic [QW:0] e;
                        bit eb;
                        e  = expq.pop_front();
                        eb = e[QW] && mon_blk_en;
                        chk(acc == e[QW-1:0], mon_narrow ? "R3 word" : "R2 word",
                            acc, e[QW-1:0]);
                        chk(blk_all == eb && blk_any == eb, "R7 block flag",
                            QW'(blk_any), QW'(eb));
                        if (mon_narrow) chk(!lane_bad, "R3 upper lanes zero",
                                            QW'(lane_bad), '0);
                    end
                    beats = 0; blk_all = 1; blk_any = 0; lane_bad = 0; acc = '0;
                end
            end
            prev_clk = lnk_clk;
            prev_dat = lnk_dat;
        end
        prev_en = cfg_tx_en;
    end

    // Randomized acknowledge when enabled.
    bit ack_rand = 0;
    always @(negedge clk) if (ack_rand) lnk_ack = ($urandom % 8) != 0;

    task automatic wr(input logic [QW-1:0] d, input bit last, input bit expect_tx);
        wr_en = 1; wr_data = d; wr_last = last;
        @(negedge clk);
        wr_en = 0;
        if (expect_tx) expq.push_back({last, d});
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            if (expq.size() == 0 && beats == 0) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int t0;
        void'($urandom(32'h5eed_0042));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state.
        chk({lnk_clk, lnk_dat, lnk_blk, st_full, st_ovf, st_tmo} == '0,
            "R10 reset outputs", QW'({lnk_clk, lnk_dat, lnk_blk, st_full, st_ovf, st_tmo}), '0);

        // R5 / R1 / R8: disabled link, fill and overflow the buffer.
        lnk_ack = 1; cfg_tx_en = 0;
        t0 = toggles;
        wr(rnd_word(), 0, 1);
        repeat (40) @(negedge clk);
        chk(toggles == t0 && lnk_dat == '0, "R5 no activity when disabled",
            QW'(toggles - t0), '0);
        chk(!st_full, "R1 one word not full", QW'(st_full), '0);
        wr(rnd_word(), 1, 1);
        chk(st_full, "R1 full after two writes", QW'(st_full), 1);
        wr(rnd_word(), 0, 0);
        chk(st_ovf && st_full, "R8 overflow flagged", QW'({st_ovf, st_full}), 3);
        cfg_blk_en = 1; mon_blk_en = 1;
        cfg_tx_en = 1;
        @(negedge clk);
        chk(!st_full, "R1 full clears on load", QW'(st_full), '0);
        t0 = words_rx;
        wait_idle();
        chk(words_rx - t0 == 2, "R8 dropped write not sent", QW'(words_rx - t0), 2);
        chk(!lnk_clk, "R2 clock low after word", QW'(lnk_clk), '0);

        // R6: acknowledge low holds the next word back.
        lnk_ack = 0;
        wr(rnd_word(), 1, 1);
        t0 = toggles;
        repeat (60) @(negedge clk);
        chk(toggles == t0 && !lnk_clk, "R6 held while ack low", QW'(toggles - t0), '0);
        lnk_ack = 1;
        wait_idle();
        chk(expq.size() == 0, "R6 sent after ack", QW'(expq.size()), '0);

        // R3: one-lane mode.
        cfg_one_bit = 1; mon_narrow = 1;
        wr(rnd_word(), 0, 1);
        wr(rnd_word(), 1, 1);
        wait_idle();
        cfg_one_bit = 0; mon_narrow = 0;

        // R9: acknowledge timeout discards the waiting word.
        cfg_tmo_en = 1; lnk_ack = 0;
        wr(rnd_word(), 0, 0);
        repeat (1023) @(posedge clk);
        @(negedge clk);
        chk(!st_tmo, "R9 no timeout at 1023", QW'(st_tmo), '0);
        @(negedge clk);
        chk(st_tmo, "R9 timeout at 1024", QW'(st_tmo), 1);
        lnk_ack = 1;
        t0 = toggles;
        repeat (200) @(negedge clk);
        chk(toggles == t0, "R9 timed-out word discarded", QW'(toggles - t0), '0);
        cfg_tmo_en = 0;

        // Random traffic in both widths with random acknowledge.
        for (int ph = 0; ph < 4; ph++) begin
            cfg_one_bit = ph[0]; mon_narrow = ph[0];
            cfg_blk_en = ph[1]; mon_blk_en = ph[1];
            ack_rand = 1;
            for (int i = 0; i < 20; i++) begin
                repeat ($urandom % 6) @(negedge clk);
                for (int k = 0; k < 1000 && st_full; k++) @(negedge clk);
                wr(rnd_word(), ($urandom % 4) == 0, 1);
            end
            wait_idle();
            ack_rand = 0; lnk_ack = 1;
            wait_idle();
        end

        chk(expq.size() == 0, "R1 all words delivered", QW'(expq.size()), '0);
        chk(r4_viol == 0, "R4 data only with clock edge", QW'(r4_viol), '0);
        chk(r2_gap == 0, "R2 clock toggles every cycle", QW'(r2_gap), '0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule